// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Receiver

This block recovers characters from one asynchronous serial line. It has no baud generator of its own. An external one-cycle strobe marks the middle of every bit time, and the receiver samples the line on that strobe only. The frame format is set at run time through static inputs:

- 7 or 8 data bits;
- least or most significant bit first;
- an optional parity bit, odd or even;
- one or two stop bits.

A loopback select makes the receiver take its line from the local transmit output instead of the pin.

Three operating modes are supported:

- **Plain mode.** Every character is treated alike.
- **Idle-line mode.** A character that follows a long run of high bit times is marked as an address.
- **Address-bit mode.** An extra marker bit follows the data bits. That marker is counted in the parity.

A dormant control suppresses the ready flag for characters that are not marked as addresses. Two further controls decide whether erroneous characters and break characters raise the ready flag. The error and status flags collect events until a buffer read pulse clears them.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, rx_ready, busy, and every error and status flag read 0.
- R2: A frame starts only when the line is low at a strobe. A low level between strobes that is high again at the next strobe is ignored. `busy` is 1 from the cycle after the start strobe until the cycle after the last stop strobe.
- R3: Data bits follow the start bit. With `len7`=1, 7 bits are received and rx_data[7] is 0. With `msb_first`=1, the first data bit received is the most significant bit of the character.
- R4: With `par_en`=1, a parity bit follows the data bits (and the address marker, when present). `par_even`=1 selects even parity and 0 selects odd parity. A mismatch sets err_pe. With `par_en`=0, there is no parity slot and err_pe never sets.
- R5: Each stop position (two when `two_stop`=1) must be high. Any stop bit sampled low sets err_fe.
- R6: If a character is stored while rx_ready is still 1, err_oe is set and rx_data takes the new character.
- R7: err_sum is set together with any of err_fe, err_pe or err_oe. A `rd_stb` pulse clears rx_ready and every flag (err_fe, err_pe, err_oe, err_sum, brk_flag, addr_flag, idle_flag) in the following cycle.
- R8: A character with a framing or parity error raises rx_ready only when `err_ie`=1. With `dormant`=0, every error-free character raises rx_ready.
- R9: A break is a frame with every bit position sampled low. A break always sets brk_flag and err_fe. It raises rx_ready, with rx_data 0, only when `brk_ie`=1.
- R10: In address-bit mode (`mode`=2), a marker bit follows the data bits. The marker is included in the parity and is reported on addr_flag. With `dormant`=1, only characters whose marker is 1 raise rx_ready.
- R11: In idle-line mode (`mode`=1), a character whose start bit follows at least IDLE_BITS consecutive high strobes sets addr_flag and idle_flag. With `dormant`=1, only such characters raise rx_ready.
- R12: With `loop_en`=1, the receiver samples `loop_tx` and ignores `rx_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe at the middle of each bit time |
| rx_line | input | 1 | Serial input, already synchronous to clk |
| loop_en | input | 1 | 1: sample loop_tx instead of rx_line |
| loop_tx | input | 1 | Local transmit line used for loopback |
| len7 | input | 1 | 1: 7 data bits; 0: 8 data bits |
| msb_first | input | 1 | 1: most significant bit first |
| par_en | input | 1 | Parity slot present |
| par_even | input | 1 | 1: even parity; 0: odd parity |
| two_stop | input | 1 | 1: two stop bits |
| mode | input | 2 | 0: plain; 1: idle-line; 2: address-bit |
| dormant | input | 1 | Pass only address-marked characters |
| err_ie | input | 1 | Erroneous characters raise rx_ready |
| brk_ie | input | 1 | Break characters raise rx_ready |
| rd_stb | input | 1 | Buffer read pulse that clears the flags |
| rx_data | output | 8 | Last accepted character |
| rx_ready | output | 1 | Character waiting in the buffer |
| err_fe | output | 1 | Framing error |
| err_pe | output | 1 | Parity error |
| err_oe | output | 1 | Overrun |
| err_sum | output | 1 | Any receive error |
| brk_flag | output | 1 | Break seen |
| addr_flag | output | 1 | Last accepted character marked as address |
| idle_flag | output | 1 | Last accepted character followed an idle line |
| busy | output | 1 | Reception in progress |

## Verification
The checker assumes three things about the inputs:

- The format and mode controls change only while no frame is in progress.
- `tick` is a single-cycle pulse.
- The line is stable around each strobe.

Under those assumptions, flag rises can be traced back to the frame-completion event, a set parity enable and the selected mode. The bench drives every control at a falling clock edge, and only between frames. Each bit is sent as one strobe followed by three quiet cycles, so each frame has finished and its flags have settled before the next task starts or any output is sampled.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_IDLE  = 2'd1,
      MODE_ADDR  = 2'd2
   } rx_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_ADDR,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       abit;
      logic       fe;
      logic       pe;
      logic       brk;
      logic       idle;
   } rx_frame_t;
endpackage

// File: rtl/mpuart_idle_det.sv
module mpuart_idle_det #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic armed,
   input  logic restart,
   output logic hit
);
   localparam int CW = $clog2(IDLE_BITS + 1);

   logic [CW-1:0] run_q;

   assign hit = (run_q == CW'(IDLE_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (restart)
         run_q <= '0;
      else if (tick && armed && line && !hit)
         run_q <= run_q + 1'b1;
   end
endmodule

// File: rtl/mpuart_deser.sv
module mpuart_deser
   import mpuart_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic       len7,
   input  logic       msb_first,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       two_stop,
   input  logic [1:0] mode,
   input  logic       idle_hit,
   output logic       armed,
   output logic       start,
   output logic       busy,
   output logic       fr_done,
   output rx_frame_t  fr
);
   localparam int BCW = $clog2(DATA_W);

   rx_state_e         st_q;
   logic [BCW-1:0]    bit_q;
   logic              stop_q;
   logic [DATA_W-1:0] sh_q;
   logic              acc_q;
   logic              low_q;
   logic              fe_q;
   logic              pe_q;
   logic              abit_q;
   logic              idle_q;
   logic [BCW-1:0]    last_bit;
   logic [DATA_W-1:0] data_c;
   logic              fe_n;
   logic              low_n;

   assign armed    = (st_q == ST_IDLE);
   assign busy     = !armed;
   assign start    = tick && armed && !line;
   assign last_bit = len7 ? BCW'(DATA_W - 2) : BCW'(DATA_W - 1);
   assign fe_n     = fe_q | !line;
   assign low_n    = low_q & !line;

   always_comb begin
      if (!len7)
         data_c = sh_q;
      else if (msb_first)
         data_c = {1'b0, sh_q[DATA_W-2:0]};
      else
         data_c = {1'b0, sh_q[DATA_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bit_q   <= '0;
         stop_q  <= 1'b0;
         sh_q    <= '0;
         acc_q   <= 1'b0;
         low_q   <= 1'b0;
         fe_q    <= 1'b0;
         pe_q    <= 1'b0;
         abit_q  <= 1'b0;
         idle_q  <= 1'b0;
         fr_done <= 1'b0;
         fr      <= '0;
      end else begin
         fr_done <= 1'b0;
         if (tick) begin
            unique case (st_q)
               ST_IDLE: if (!line) begin
                  st_q   <= ST_DATA;
                  bit_q  <= '0;
                  sh_q   <= '0;
                  acc_q  <= 1'b0;
                  low_q  <= 1'b1;
                  fe_q   <= 1'b0;
                  pe_q   <= 1'b0;
                  abit_q <= 1'b0;
                  idle_q <= idle_hit;
               end
               ST_DATA: begin
                  sh_q  <= msb_first ? {sh_q[DATA_W-2:0], line}
                                     : {line, sh_q[DATA_W-1:1]};
                  acc_q <= acc_q ^ line;
                  low_q <= low_n;
                  if (bit_q == last_bit) begin
                     stop_q <= 1'b0;
                     if (mode == MODE_ADDR) st_q <= ST_ADDR;
                     else if (par_en)       st_q <= ST_PAR;
                     else                   st_q <= ST_STOP;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
               ST_ADDR: begin
                  abit_q <= line;
                  acc_q  <= acc_q ^ line;
                  low_q  <= low_n;
                  st_q   <= par_en ? ST_PAR : ST_STOP;
               end
               ST_PAR: begin
                  pe_q  <= acc_q ^ line ^ !par_even;
                  low_q <= low_n;
                  st_q  <= ST_STOP;
               end
               ST_STOP: begin
                  if (stop_q == two_stop) begin
                     st_q    <= ST_IDLE;
                     fr_done <= 1'b1;
                     fr.data <= data_c;
                     fr.abit <= abit_q;
                     fr.fe   <= fe_n;
                     fr.pe   <= pe_q;
                     fr.brk  <= low_n;
                     fr.idle <= idle_q;
                  end else begin
                     stop_q <= 1'b1;
                     fe_q   <= fe_n;
                     low_q  <= low_n;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mpuart_status.sv
module mpuart_status
   import mpuart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fr_done,
   input  rx_frame_t  fr,
   input  logic [1:0] mode,
   input  logic       dormant,
   input  logic       err_ie,
   input  logic       brk_ie,
   input  logic       rd,
   output logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       err_fe,
   output logic       err_pe,
   output logic       err_oe,
   output logic       err_sum,
   output logic       brk_flag,
   output logic       addr_flag,
   output logic       idle_flag
);
   logic wake, clean, raise, ovr, new_addr, new_idle, keep;

   always_comb begin
      unique case (mode)
         MODE_IDLE: begin wake = fr.idle; new_addr = fr.idle; end
         MODE_ADDR: begin wake = fr.abit; new_addr = fr.abit; end
         default:   begin wake = 1'b1;    new_addr = 1'b0;    end
      endcase
      new_idle = (mode == MODE_IDLE) && fr.idle;
      clean    = !(fr.fe || fr.pe) || err_ie;
      raise    = fr_done && (fr.brk ? brk_ie : (clean && (!dormant || wake)));
      keep     = !rd;
      ovr      = raise && rx_ready && keep;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         rx_ready  <= 1'b0;
         err_fe    <= 1'b0;
         err_pe    <= 1'b0;
         err_oe    <= 1'b0;
         err_sum   <= 1'b0;
         brk_flag  <= 1'b0;
         addr_flag <= 1'b0;
         idle_flag <= 1'b0;
      end else begin
         rx_ready <= (rx_ready & keep) | raise;
         err_fe   <= (err_fe   & keep) | (fr_done & fr.fe);
         err_pe   <= (err_pe   & keep) | (fr_done & fr.pe);
         err_oe   <= (err_oe   & keep) | ovr;
         err_sum  <= (err_sum  & keep) | (fr_done & (fr.fe | fr.pe)) | ovr;
         brk_flag <= (brk_flag & keep) | (fr_done & fr.brk);
         if (raise) begin
            rx_data   <= fr.data;
            addr_flag <= new_addr;
            idle_flag <= new_idle;
         end else begin
            addr_flag <= addr_flag & keep;
            idle_flag <= idle_flag & keep;
         end
      end
   end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int IDLE_BITS = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_line,
   input  logic       loop_en,
   input  logic       loop_tx,
   input  logic       len7,
   input  logic       msb_first,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       two_stop,
   input  logic [1:0] mode,
   input  logic       dormant,
   input  logic       err_ie,
   input  logic       brk_ie,
   input  logic       rd_stb,
   output logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       err_fe,
   output logic       err_pe,
   output logic       err_oe,
   output logic       err_sum,
   output logic       brk_flag,
   output logic       addr_flag,
   output logic       idle_flag,
   output logic       busy
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("mpuart_rx: DATA_W must be 8");
      end
      if (IDLE_BITS < 10) begin : g_bad_idle
         $error("mpuart_rx: IDLE_BITS must be at least 10");
      end
   endgenerate

   logic      line_in;
   logic      armed, start, idle_hit, fr_done;
   rx_frame_t fr;

   assign line_in = loop_en ? loop_tx : rx_line;

   mpuart_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_in),
      .armed(armed), .restart(start), .hit(idle_hit)
   );

   mpuart_deser #(.DATA_W(DATA_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_in),
      .len7(len7), .msb_first(msb_first), .par_en(par_en),
      .par_even(par_even), .two_stop(two_stop), .mode(mode),
      .idle_hit(idle_hit), .armed(armed), .start(start), .busy(busy),
      .fr_done(fr_done), .fr(fr)
   );

   mpuart_status u_stat (
      .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr(fr), .mode(mode),
      .dormant(dormant), .err_ie(err_ie), .brk_ie(brk_ie), .rd(rd_stb),
      .rx_data(rx_data), .rx_ready(rx_ready), .err_fe(err_fe),
      .err_pe(err_pe), .err_oe(err_oe), .err_sum(err_sum),
      .brk_flag(brk_flag), .addr_flag(addr_flag), .idle_flag(idle_flag)
   );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       line_in,
   input logic       par_en,
   input logic [1:0] mode,
   input logic       rd_stb,
   input logic       fr_done,
   input logic       rx_ready,
   input logic       err_fe,
   input logic       err_pe,
   input logic       err_oe,
   input logic       err_sum,
   input logic       brk_flag,
   input logic       idle_flag,
   input logic       busy
);
   p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(tick) && !$past(line_in)));

   p_pe_needs_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_pe) |-> $past(par_en));

   p_oe_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_oe) |-> $past(rx_ready));

   p_sum_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_fe || err_pe || err_oe) |-> err_sum);

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !fr_done) |=> (!rx_ready && !err_sum && !err_oe));

   p_ready_from_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> $past(fr_done));

   p_break_framing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag) |-> err_fe);

   p_idle_only_in_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_flag) |-> ($past(mode) == 2'd1));
endmodule

bind mpuart_rx mpuart_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
   .par_en(par_en), .mode(mode), .rd_stb(rd_stb), .fr_done(fr_done),
   .rx_ready(rx_ready), .err_fe(err_fe), .err_pe(err_pe),
   .err_oe(err_oe), .err_sum(err_sum), .brk_flag(brk_flag),
   .idle_flag(idle_flag), .busy(busy)
);

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, rx_line = 1'b1, loop_en = 1'b0, loop_tx = 1'b1;
   logic len7 = 1'b0, msb_first = 1'b0, par_en = 1'b0, par_even = 1'b0;
   logic two_stop = 1'b0, dormant = 1'b0, err_ie = 1'b0, brk_ie = 1'b0;
   logic rd_stb = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [7:0] rx_data;
   logic rx_ready, err_fe, err_pe, err_oe, err_sum;
   logic brk_flag, addr_flag, idle_flag, busy;
   logic lb_sel = 1'b0;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mpuart_rx dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
      .loop_en(loop_en), .loop_tx(loop_tx), .len7(len7),
      .msb_first(msb_first), .par_en(par_en), .par_even(par_even),
      .two_stop(two_stop), .mode(mode), .dormant(dormant),
      .err_ie(err_ie), .brk_ie(brk_ie), .rd_stb(rd_stb),
      .rx_data(rx_data), .rx_ready(rx_ready), .err_fe(err_fe),
      .err_pe(err_pe), .err_oe(err_oe), .err_sum(err_sum),
      .brk_flag(brk_flag), .addr_flag(addr_flag), .idle_flag(idle_flag),
      .busy(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      @(negedge clk);
      if (lb_sel) loop_tx = b; else rx_line = b;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic idle_bits(input int n);
      for (int i = 0; i < n; i++) bit_out(1'b1);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   // bad_stop: 0 none, 1 first stop low, 2 second stop low
   task automatic send_frame(input logic [7:0] d, input logic abit,
                             input logic bad_par, input int bad_stop);
      int   nb;
      logic ones;
      nb = len7 ? 7 : 8;
      ones = 1'b0;
      bit_out(1'b0);
      for (int i = 0; i < nb; i++) begin
         bit_out(d[msb_first ? nb - 1 - i : i]);
         ones ^= d[i];
      end
      if (mode == 2'd2) begin
         bit_out(abit);
         ones ^= abit;
      end
      if (par_en) bit_out((par_even ? ones : ~ones) ^ bad_par);
      bit_out(bad_stop == 1 ? 1'b0 : 1'b1);
      if (two_stop) bit_out(bad_stop == 2 ? 1'b0 : 1'b1);
   endtask

   task automatic send_break();
      int n;
      n = 1 + (len7 ? 7 : 8) + (mode == 2'd2 ? 1 : 0) + (par_en ? 1 : 0)
          + (two_stop ? 2 : 1);
      for (int i = 0; i < n; i++) bit_out(1'b0);
      idle_bits(2);
   endtask

   task automatic t_reset();
      chk("R1 ready", rx_ready, 0);
      chk("R1 busy", busy, 0);
      chk("R1 sum", err_sum, 0);
      chk("R1 flags", {err_fe, err_pe, err_oe, brk_flag, addr_flag, idle_flag}, 0);
   endtask

   task automatic t_plain();
      idle_bits(2);
      send_frame(8'hA5, 1'b0, 1'b0, 0);
      chk("R3 lsb8 data", rx_data, 8'hA5);
      chk("R8 ready", rx_ready, 1);
      chk("R4 pe off", err_pe, 0);
      chk("R5 fe clean", err_fe, 0);
      chk("R10 addr plain", addr_flag, 0);
      do_read();
      chk("R7 read clears ready", rx_ready, 0);
   endtask

   task automatic t_formats();
      len7 = 1'b1; msb_first = 1'b1;
      send_frame(8'h5B, 1'b0, 1'b0, 0);
      chk("R3 msb7 data", rx_data, 8'h5B);
      do_read();
      msb_first = 1'b0;
      send_frame(8'hC3, 1'b0, 1'b0, 0);
      chk("R3 lsb7 data", rx_data, 8'h43);
      do_read();
      len7 = 1'b0; msb_first = 1'b1;
      send_frame(8'h81, 1'b0, 1'b0, 0);
      chk("R3 msb8 data", rx_data, 8'h81);
      do_read();
      msb_first = 1'b0;
   endtask

   task automatic t_parity();
      par_en = 1'b1; par_even = 1'b1;
      send_frame(8'h71, 1'b0, 1'b0, 0);
      chk("R4 even good pe", err_pe, 0);
      chk("R4 even good ready", rx_ready, 1);
      do_read();
      par_even = 1'b0;
      send_frame(8'h71, 1'b0, 1'b1, 0);
      chk("R4 odd bad pe", err_pe, 1);
      chk("R7 sum on pe", err_sum, 1);
      chk("R8 rejected", rx_ready, 0);
      do_read();
      chk("R7 pe cleared", err_pe, 0);
      err_ie = 1'b1;
      send_frame(8'h0F, 1'b0, 1'b1, 0);
      chk("R8 err_ie ready", rx_ready, 1);
      chk("R8 err_ie data", rx_data, 8'h0F);
      do_read();
      err_ie = 1'b0; par_en = 1'b0;
   endtask

   task automatic t_framing();
      two_stop = 1'b1; err_ie = 1'b1;
      send_frame(8'h12, 1'b0, 1'b0, 2);
      chk("R5 second stop low fe", err_fe, 1);
      chk("R7 sum on fe", err_sum, 1);
      do_read();
      send_frame(8'h34, 1'b0, 1'b0, 0);
      chk("R5 two stops fe", err_fe, 0);
      chk("R5 two stops data", rx_data, 8'h34);
      do_read();
      two_stop = 1'b0; err_ie = 1'b0;
   endtask

   task automatic t_overrun();
      send_frame(8'h11, 1'b0, 1'b0, 0);
      chk("R6 first no oe", err_oe, 0);
      send_frame(8'h22, 1'b0, 1'b0, 0);
      chk("R6 oe", err_oe, 1);
      chk("R6 data newest", rx_data, 8'h22);
      chk("R7 sum on oe", err_sum, 1);
      do_read();
      chk("R6 oe cleared", err_oe, 0);
      chk("R7 sum cleared", err_sum, 0);
   endtask

   task automatic t_break();
      err_ie = 1'b1; brk_ie = 1'b0;
      send_break();
      chk("R9 brk flag", brk_flag, 1);
      chk("R9 brk fe", err_fe, 1);
      chk("R9 brk no ready", rx_ready, 0);
      do_read();
      chk("R7 brk cleared", brk_flag, 0);
      brk_ie = 1'b1;
      send_break();
      chk("R9 brk_ie ready", rx_ready, 1);
      chk("R9 brk data", rx_data, 0);
      do_read();
      err_ie = 1'b0; brk_ie = 1'b0;
   endtask

   task automatic t_addr();
      mode = 2'd2; par_en = 1'b1; par_even = 1'b0; dormant = 1'b1;
      send_frame(8'h40, 1'b0, 1'b0, 0);
      chk("R10 dormant data blocked", rx_ready, 0);
      send_frame(8'h40, 1'b1, 1'b0, 0);
      chk("R10 address passes", rx_ready, 1);
      chk("R10 addr flag", addr_flag, 1);
      chk("R10 marker in parity", err_pe, 0);
      do_read();
      dormant = 1'b0;
      send_frame(8'h41, 1'b0, 1'b0, 0);
      chk("R10 awake data", rx_ready, 1);
      chk("R10 data addr flag", addr_flag, 0);
      do_read();
      mode = 2'd0; par_en = 1'b0;
   endtask

   task automatic t_idle();
      mode = 2'd1; dormant = 1'b1;
      idle_bits(3);
      send_frame(8'h55, 1'b0, 1'b0, 0);
      chk("R11 short gap blocked", rx_ready, 0);
      idle_bits(12);
      send_frame(8'h66, 1'b0, 1'b0, 0);
      chk("R11 after idle ready", rx_ready, 1);
      chk("R11 idle flag", idle_flag, 1);
      chk("R11 addr flag", addr_flag, 1);
      chk("R11 data", rx_data, 8'h66);
      do_read();
      chk("R7 idle flag cleared", idle_flag, 0);
      idle_bits(1);
      send_frame(8'h77, 1'b0, 1'b0, 0);
      chk("R11 no idle blocked", rx_ready, 0);
      mode = 2'd0; dormant = 1'b0;
   endtask

   task automatic t_glitch();
      idle_bits(2);
      @(negedge clk) rx_line = 1'b0;
      @(negedge clk) rx_line = 1'b1;
      idle_bits(2);
      chk("R2 glitch not start", busy, 0);
      chk("R2 glitch no char", rx_ready, 0);
      bit_out(1'b0);
      chk("R2 busy after start", busy, 1);
      for (int i = 0; i < 8; i++) bit_out(1'b1);
      chk("R2 busy mid frame", busy, 1);
      bit_out(1'b1);
      chk("R2 busy ends", busy, 0);
      chk("R2 frame data", rx_data, 8'hFF);
      do_read();
   endtask

   task automatic t_loop();
      loop_en = 1'b1; lb_sel = 1'b1; rx_line = 1'b0;
      idle_bits(2);
      send_frame(8'h3A, 1'b0, 1'b0, 0);
      chk("R12 loopback data", rx_data, 8'h3A);
      chk("R12 loopback ready", rx_ready, 1);
      do_read();
      loop_en = 1'b0; lb_sel = 1'b0; rx_line = 1'b1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_formats();
      t_parity();
      t_framing();
      t_overrun();
      t_break();
      t_addr();
      t_idle();
      t_glitch();
      t_loop();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule